// File: doc/BRIEF.md
# Round-robin link request distributor

This block sits between a single upstream request port and several downstream serial links that all serve the same address space. Each request presented upstream goes to the link named by a rotating pointer. The pointer steps on every cycle in which a request is offered, whether or not that request is taken. Each link has an occupancy counter. A request aimed at an occupied link is turned away at once and is never sent to a different link. A request aimed at a free link is offered on that link's valid/ready pair. If the link does not take it, the upstream side is told to retry, and the link stays occupied for one cycle.

Requests that expect an answer, and that are not inhibited, leave their requester tag in a route table indexed by request ID. When the response arrives, the table supplies that tag and frees the entry. The table holds a fixed number of entries. When it is full, only requests that need a table entry are held back. Address-range updates are adopted from link 0 only; updates from the other links are merely noted as seen. Counters keep, for each requester/link pair, the number of packets and the sum of payload bytes. A further counter per command code counts requests by command.

Top module: `rr_link_distributor`

## Requirements
- R1: After reset the pointer is 0. Every cycle with `req_valid` high is one attempt and targets link `ptr`. The pointer then advances by one and wraps from N_LINKS-1 to 0, whether or not the attempt succeeded.
- R2: If the targeted link is occupied (`link_busy` bit high), `req_ready` is low, no `link_valid` bit is raised and the request goes to no other link. A rejected request is held unchanged by the upstream side until it is accepted.
- R3: If the targeted link is free but its `link_ready` bit is low, its `link_valid` bit is high and `req_ready` is low. That link's `link_busy` bit is then high for exactly the next cycle.
- R4: An accepted request makes the chosen link's `link_busy` bit high for 1 + ceil(bytes/BEAT_BYTES) cycles after the accepting edge. Here bytes is `req_len` when `req_cmd[0]`=1 (a command that carries data), and 0 otherwise.
- R5: `link_delay` equals `req_delay` + FRONT_LAT + FWD_LAT modulo 2^DLY_W. `link_addr`, `link_cmd`, `link_len` and `link_id` equal the request fields.
- R6: An accepted request with `req_need_rsp`=1 and `req_inhibit`=0 stores `req_src` under `req_id`. A cycle with `rsp_in_valid` and a stored `rsp_in_id` gives `rsp_out_valid`=1 with the stored tag in the next cycle and frees the entry. An ID that is not stored gives no output.
- R7: A request that needs an entry, and whose ID is already stored, raises `dup_err` in that cycle and is rejected.
- R8: While MAX_OUT entries are stored, requests that need an entry are rejected. Requests that need no entry are still forwarded.
- R9: A range update on link 0 loads `range_base`/`range_last` from the shared update bus one cycle later. Updates on other links leave them unchanged. Each update sets its link's bit in `range_seen`.
- R10: Each accepted request adds 1 to the packet count and adds bytes (as in R4) to the byte sum of pair (`req_src`, chosen link), and adds 1 to the count of `req_cmd`. The selected values appear on the `stat_*` outputs one cycle after the select inputs.
- R11: During reset all occupancy, table entries, pointer, range registers and counters are cleared, and all `stat_*` outputs read 0.
- R12: At most one `link_valid` bit is high, and only while `req_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Upstream request offered |
| req_ready | output | 1 | Upstream request accepted this cycle |
| req_addr | input | ADDR_W | Request address |
| req_cmd | input | 2 | Command code, bit 0 set when the request carries data |
| req_len | input | LEN_W | Payload size in bytes |
| req_id | input | ID_W | Request ID, the route table key |
| req_src | input | SRC_W | Requester tag |
| req_need_rsp | input | 1 | Request expects a response |
| req_inhibit | input | 1 | Response suppressed, no entry stored |
| req_delay | input | DLY_W | Accumulated header delay |
| dup_err | output | 1 | ID already stored for a request that needs an entry |
| link_valid | output | N_LINKS | Request offered to each link |
| link_ready | input | N_LINKS | Link takes the offered request |
| link_addr | output | ADDR_W | Forwarded address |
| link_cmd | output | 2 | Forwarded command |
| link_len | output | LEN_W | Forwarded length |
| link_id | output | ID_W | Forwarded ID |
| link_delay | output | DLY_W | Header delay plus block latency |
| link_busy | output | N_LINKS | Link occupancy |
| rsp_in_valid | input | 1 | Response arriving |
| rsp_in_id | input | ID_W | ID of the arriving response |
| rsp_out_valid | output | 1 | Response routed back |
| rsp_out_src | output | SRC_W | Requester tag of the routed response |
| rng_upd_valid | input | N_LINKS | Range update from each link |
| rng_upd_base | input | ADDR_W | Shared update bus, range start |
| rng_upd_last | input | ADDR_W | Shared update bus, range end |
| range_base | output | ADDR_W | Adopted range start |
| range_last | output | ADDR_W | Adopted range end |
| range_seen | output | N_LINKS | Links that have sent an update |
| stat_src | input | SRC_W | Counter select, requester |
| stat_dst | input | PW | Counter select, link |
| stat_cmd | input | 2 | Counter select, command |
| stat_pkts | output | CNT_W | Packet count of the selected pair |
| stat_bytes | output | BYTE_W | Byte sum of the selected pair |
| stat_cmd_cnt | output | CNT_W | Count of the selected command |

## Verification
Random traffic mixes data and no-data commands with random lengths, IDs, need-response and inhibit flags, and random per-link ready. It separates the three outcomes of an attempt: a busy reject, a link refusal and an accept. It also shows that the pointer moves even when an attempt fails. Directed runs first fill the route table. They then show that a request needing no entry passes while one needing an entry waits, that a repeated ID raises the error until its response frees it, and that all-refusing links give one-cycle occupancy. A range sequence updates a non-zero link before link 0, which tells adoption apart from mere marking. A final readback of every requester/link pair and every command shows that the counters are attributed to the right pair.

// File: rtl/rrd_pkg.sv
package rrd_pkg;

  typedef enum logic [1:0] {
    CMD_READ   = 2'd0,
    CMD_WRITE  = 2'd1,
    CMD_FLUSH  = 2'd2,
    CMD_WRPOST = 2'd3
  } rrd_cmd_e;

  function automatic logic cmd_has_data(input logic [1:0] cmd);
    return cmd[0];
  endfunction

endpackage

// File: rtl/rrd_rr_pointer.sv
module rrd_rr_pointer #(
  parameter int N  = 4,
  parameter int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          advance,
  output logic [PW-1:0] ptr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (advance) begin
      ptr <= (ptr == PW'(N - 1)) ? '0 : ptr + PW'(1);
    end
  end

  // R1: the pointer never names a link that does not exist
  a_r1_ptr_range: assert property (@(posedge clk) disable iff (rst)
    {1'b0, ptr} < (PW + 1)'(N));

  // R1: one step per attempt, with wrap
  a_r1_ptr_step: assert property (@(posedge clk) disable iff (rst)
    advance |=> (ptr == (($past(ptr) == PW'(N - 1)) ? '0 : $past(ptr) + PW'(1))));

endmodule

// File: rtl/rrd_link_layer.sv
module rrd_link_layer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          grant,
  input  logic          refuse,
  input  logic [CW-1:0] hold_cycles,
  output logic          busy
);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
    end else if (grant) begin
      remain <= hold_cycles;
    end else if (refuse) begin
      remain <= CW'(1);
    end else if (remain != '0) begin
      remain <= remain - CW'(1);
    end
  end

  assign busy = (remain != '0);

  // R4: an accepted transfer occupies the layer on the next cycle
  a_r4_busy_after_grant: assert property (@(posedge clk) disable iff (rst)
    grant |=> busy);

  // R3: a refusal occupies the layer for exactly one cycle
  a_r3_refuse_one_cycle: assert property (@(posedge clk) disable iff (rst)
    refuse |=> busy ##1 !busy);

  // R2: nothing is offered to an occupied layer
  a_r2_no_offer_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> !(grant || refuse));

endmodule

// File: rtl/rrd_route_table.sv
module rrd_route_table #(
  parameter int ID_W    = 4,
  parameter int SRC_W   = 2,
  parameter int MAX_OUT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ID_W-1:0]  look_id,
  output logic             hit,
  output logic             full,
  input  logic             wr_en,
  input  logic [SRC_W-1:0] wr_src,
  input  logic             rd_en,
  input  logic [ID_W-1:0]  rd_id,
  output logic             rsp_valid,
  output logic [SRC_W-1:0] rsp_src
);

  localparam int DEPTH = 1 << ID_W;
  localparam int OW    = $clog2(MAX_OUT + 1);

  logic [SRC_W-1:0] tag_mem [DEPTH];
  logic [DEPTH-1:0] live;
  logic [OW-1:0]    used;
  logic             release_hit;

  assign hit         = live[look_id];
  assign full        = (used == OW'(MAX_OUT));
  assign release_hit = rd_en && live[rd_id];

  // tag storage without reset, registered read
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[look_id] <= wr_src;
    end
    rsp_src <= tag_mem[rd_id];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live      <= '0;
      used      <= '0;
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= release_hit;
      used      <= used + OW'(wr_en) - OW'(release_hit);
      if (release_hit) begin
        live[rd_id] <= 1'b0;
      end
      if (wr_en) begin
        live[look_id] <= 1'b1;
      end
    end
  end

  // R8: occupancy never exceeds the table capacity
  a_r8_used_cap: assert property (@(posedge clk) disable iff (rst)
    {1'b0, used} <= (OW + 1)'(MAX_OUT));

  // R8: no entry is written while the table is full
  a_r8_no_write_full: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !full);

  // R7: an ID is never stored twice
  a_r7_no_dup_write: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !hit);

endmodule

// File: rtl/rrd_stat_bank.sv
module rrd_stat_bank #(
  parameter int N_SRC  = 4,
  parameter int N_DST  = 4,
  parameter int N_CMD  = 4,
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 24,
  parameter int LEN_W  = 8,
  parameter int SRC_W  = 2,
  parameter int DST_W  = 2,
  parameter int CMD_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic [SRC_W-1:0]  upd_src,
  input  logic [DST_W-1:0]  upd_dst,
  input  logic [CMD_W-1:0]  upd_cmd,
  input  logic [LEN_W-1:0]  upd_bytes,
  input  logic [SRC_W-1:0]  rd_src,
  input  logic [DST_W-1:0]  rd_dst,
  input  logic [CMD_W-1:0]  rd_cmd,
  output logic [CNT_W-1:0]  rd_pkts,
  output logic [BYTE_W-1:0] rd_bytes,
  output logic [CNT_W-1:0]  rd_cmd_cnt
);

  localparam int PAIRS = N_SRC * N_DST;
  localparam int IW    = (PAIRS > 1) ? $clog2(PAIRS) : 1;

  logic [CNT_W-1:0]  pkt_cnt  [PAIRS];
  logic [BYTE_W-1:0] byte_sum [PAIRS];
  logic [CNT_W-1:0]  cmd_cnt  [N_CMD];
  logic [IW-1:0]     wr_idx, rd_idx;

  assign wr_idx = IW'(int'(upd_src) * N_DST + int'(upd_dst));
  assign rd_idx = IW'(int'(rd_src) * N_DST + int'(rd_dst));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < PAIRS; p++) begin
        pkt_cnt[p]  <= '0;
        byte_sum[p] <= '0;
      end
      for (int c = 0; c < N_CMD; c++) begin
        cmd_cnt[c] <= '0;
      end
      rd_pkts    <= '0;
      rd_bytes   <= '0;
      rd_cmd_cnt <= '0;
    end else begin
      if (upd) begin
        pkt_cnt[wr_idx]  <= pkt_cnt[wr_idx] + CNT_W'(1);
        byte_sum[wr_idx] <= byte_sum[wr_idx] + BYTE_W'(upd_bytes);
        cmd_cnt[upd_cmd] <= cmd_cnt[upd_cmd] + CNT_W'(1);
      end
      rd_pkts    <= pkt_cnt[rd_idx];
      rd_bytes   <= byte_sum[rd_idx];
      rd_cmd_cnt <= cmd_cnt[rd_cmd];
    end
  end

endmodule

// File: rtl/rr_link_distributor.sv
module rr_link_distributor
  import rrd_pkg::*;
#(
  parameter int N_LINKS    = 4,
  parameter int N_SRC      = 4,
  parameter int ADDR_W     = 32,
  parameter int ID_W       = 4,
  parameter int LEN_W      = 8,
  parameter int DLY_W      = 8,
  parameter int BEAT_BYTES = 16,
  parameter int FRONT_LAT  = 2,
  parameter int FWD_LAT    = 1,
  parameter int MAX_OUT    = 4,
  parameter int CNT_W      = 16,
  parameter int BYTE_W     = 24,
  parameter int PW         = (N_LINKS > 1) ? $clog2(N_LINKS) : 1,
  parameter int SRC_W      = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [1:0]         req_cmd,
  input  logic [LEN_W-1:0]   req_len,
  input  logic [ID_W-1:0]    req_id,
  input  logic [SRC_W-1:0]   req_src,
  input  logic               req_need_rsp,
  input  logic               req_inhibit,
  input  logic [DLY_W-1:0]   req_delay,
  output logic               dup_err,
  output logic [N_LINKS-1:0] link_valid,
  input  logic [N_LINKS-1:0] link_ready,
  output logic [ADDR_W-1:0]  link_addr,
  output logic [1:0]         link_cmd,
  output logic [LEN_W-1:0]   link_len,
  output logic [ID_W-1:0]    link_id,
  output logic [DLY_W-1:0]   link_delay,
  output logic [N_LINKS-1:0] link_busy,
  input  logic               rsp_in_valid,
  input  logic [ID_W-1:0]    rsp_in_id,
  output logic               rsp_out_valid,
  output logic [SRC_W-1:0]   rsp_out_src,
  input  logic [N_LINKS-1:0] rng_upd_valid,
  input  logic [ADDR_W-1:0]  rng_upd_base,
  input  logic [ADDR_W-1:0]  rng_upd_last,
  output logic [ADDR_W-1:0]  range_base,
  output logic [ADDR_W-1:0]  range_last,
  output logic [N_LINKS-1:0] range_seen,
  input  logic [SRC_W-1:0]   stat_src,
  input  logic [PW-1:0]      stat_dst,
  input  logic [1:0]         stat_cmd,
  output logic [CNT_W-1:0]   stat_pkts,
  output logic [BYTE_W-1:0]  stat_bytes,
  output logic [CNT_W-1:0]   stat_cmd_cnt
);

  localparam int MAX_BEATS = ((1 << LEN_W) - 1 + BEAT_BYTES - 1) / BEAT_BYTES;
  localparam int CW        = $clog2(MAX_BEATS + 2);
  localparam int XLAT      = FRONT_LAT + FWD_LAT;

  logic [PW-1:0]      sel;
  logic [N_LINKS-1:0] busy_v;
  logic               need_rec, tbl_hit, tbl_full, rec_block;
  logic               sel_free, fwd, accept, refuse;
  logic [LEN_W-1:0]   data_bytes;
  logic [LEN_W:0]     rounded;
  logic [CW-1:0]      hold_cyc;

  // rotation: every offered request consumes a slot
  rrd_rr_pointer #(.N(N_LINKS), .PW(PW)) u_ptr (
    .clk     (clk),
    .rst     (rst),
    .advance (req_valid),
    .ptr     (sel)
  );

  // occupancy time of an accepted transfer
  assign data_bytes = cmd_has_data(req_cmd) ? req_len : '0;
  assign rounded    = {1'b0, data_bytes} + (LEN_W + 1)'(BEAT_BYTES - 1);
  assign hold_cyc   = CW'(rounded / (LEN_W + 1)'(BEAT_BYTES)) + CW'(1);

  // decision for this cycle
  assign need_rec  = req_need_rsp && !req_inhibit;
  assign rec_block = need_rec && (tbl_full || tbl_hit);
  assign sel_free  = !busy_v[sel];
  assign fwd       = req_valid && sel_free && !rec_block;
  assign accept    = fwd && link_ready[sel];
  assign refuse    = fwd && !link_ready[sel];
  assign req_ready = accept;
  assign dup_err   = req_valid && need_rec && tbl_hit;

  // shared payload toward the links
  assign link_addr  = req_addr;
  assign link_cmd   = req_cmd;
  assign link_len   = req_len;
  assign link_id    = req_id;
  assign link_delay = req_delay + DLY_W'(XLAT);

  for (genvar i = 0; i < N_LINKS; i++) begin : g_link
    logic hit_me;
    assign hit_me        = (sel == PW'(i));
    assign link_valid[i] = fwd && hit_me;

    rrd_link_layer #(.CW(CW)) u_layer (
      .clk         (clk),
      .rst         (rst),
      .grant       (accept && hit_me),
      .refuse      (refuse && hit_me),
      .hold_cycles (hold_cyc),
      .busy        (busy_v[i])
    );
  end

  assign link_busy = busy_v;

  rrd_route_table #(.ID_W(ID_W), .SRC_W(SRC_W), .MAX_OUT(MAX_OUT)) u_route (
    .clk       (clk),
    .rst       (rst),
    .look_id   (req_id),
    .hit       (tbl_hit),
    .full      (tbl_full),
    .wr_en     (accept && need_rec),
    .wr_src    (req_src),
    .rd_en     (rsp_in_valid),
    .rd_id     (rsp_in_id),
    .rsp_valid (rsp_out_valid),
    .rsp_src   (rsp_out_src)
  );

  rrd_stat_bank #(
    .N_SRC(N_SRC), .N_DST(N_LINKS), .N_CMD(4), .CNT_W(CNT_W), .BYTE_W(BYTE_W),
    .LEN_W(LEN_W), .SRC_W(SRC_W), .DST_W(PW), .CMD_W(2)
  ) u_stats (
    .clk        (clk),
    .rst        (rst),
    .upd        (accept),
    .upd_src    (req_src),
    .upd_dst    (sel),
    .upd_cmd    (req_cmd),
    .upd_bytes  (data_bytes),
    .rd_src     (stat_src),
    .rd_dst     (stat_dst),
    .rd_cmd     (stat_cmd),
    .rd_pkts    (stat_pkts),
    .rd_bytes   (stat_bytes),
    .rd_cmd_cnt (stat_cmd_cnt)
  );

  // range adoption: link 0 is authoritative, the rest only mark
  always_ff @(posedge clk) begin
    if (rst) begin
      range_base <= '0;
      range_last <= '0;
      range_seen <= '0;
    end else begin
      range_seen <= range_seen | rng_upd_valid;
      if (rng_upd_valid[0]) begin
        range_base <= rng_upd_base;
        range_last <= rng_upd_last;
      end
    end
  end

  // R12: at most one link is offered a request
  a_r12_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(link_valid));

  // R12: no offer without an upstream request
  a_r12_valid_needs_req: assert property (@(posedge clk) disable iff (rst)
    (link_valid != '0) |-> req_valid);

  // R2: upstream holds a rejected request unchanged
  a_r2_hold_rejected: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_id)
                                  && $stable(req_cmd) && $stable(req_len)));

  // R9: non-zero links never move the adopted range
  a_r9_range_keep: assert property (@(posedge clk) disable iff (rst)
    !rng_upd_valid[0] |=> ($stable(range_base) && $stable(range_last)));

  // R9: link 0 update is adopted on the next cycle
  a_r9_range_take: assert property (@(posedge clk) disable iff (rst)
    rng_upd_valid[0] |=> (range_base == $past(rng_upd_base)));

endmodule

// File: tb/rr_link_distributor_tb.sv
module rr_link_distributor_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NL   = 4;
  localparam int MAXO = 4;
  localparam int XLAT = 3;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_ready;
  logic [31:0] req_addr;
  logic [1:0]  req_cmd;
  logic [7:0]  req_len;
  logic [3:0]  req_id;
  logic [1:0]  req_src;
  logic        req_need_rsp, req_inhibit;
  logic [7:0]  req_delay;
  logic        dup_err;
  logic [3:0]  link_valid, link_ready, link_busy;
  logic [31:0] link_addr;
  logic [1:0]  link_cmd;
  logic [7:0]  link_len;
  logic [3:0]  link_id;
  logic [7:0]  link_delay;
  logic        rsp_in_valid, rsp_out_valid;
  logic [3:0]  rsp_in_id;
  logic [1:0]  rsp_out_src;
  logic [3:0]  rng_upd_valid, range_seen;
  logic [31:0] rng_upd_base, rng_upd_last, range_base, range_last;
  logic [1:0]  stat_src, stat_dst, stat_cmd;
  logic [15:0] stat_pkts, stat_cmd_cnt;
  logic [23:0] stat_bytes;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rr_link_distributor u_dut (.*);

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // reference model state
  int m_ptr;
  int m_cnt [NL];
  bit m_vld [16];
  int m_src [16];
  int m_out;
  bit m_rspv;
  int m_rsps;
  int m_pk [16];
  int m_by [16];
  int m_cc [4];

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int beats_of(input int cmd, input int len);
    return (cmd % 2 == 1) ? (len + 15) / 16 : 0;
  endfunction

  // one cycle: inputs already driven after the falling edge
  task automatic step(output bit acc);
    int sel, bexp, nb;
    bit rec, hit, blk, fwd, rf, fr;
    #1;
    sel = m_ptr;
    rec = req_need_rsp && !req_inhibit;
    hit = m_vld[req_id];
    blk = rec && (m_out == MAXO || hit);
    fwd = req_valid && (m_cnt[sel] == 0) && !blk;
    acc = fwd && link_ready[sel];
    rf  = fwd && !link_ready[sel];
    chk("R1 R2 R12 link_valid", int'(link_valid), fwd ? (1 << sel) : 0);
    chk("R2 R3 R8 req_ready", int'(req_ready), int'(acc));
    chk("R7 dup_err", int'(dup_err), int'(req_valid && rec && hit));
    if (fwd) begin
      chk("R5 link_delay", int'(link_delay), (int'(req_delay) + XLAT) % 256);
      chk("R5 link_addr", int'(link_addr[15:0]), int'(req_addr[15:0]));
      chk("R5 link_len", int'(link_len), int'(req_len));
    end
    bexp = 0;
    for (int i = 0; i < NL; i++) if (m_cnt[i] != 0) bexp |= (1 << i);
    chk("R3 R4 link_busy", int'(link_busy), bexp);
    chk("R6 rsp_out_valid", int'(rsp_out_valid), int'(m_rspv));
    if (m_rspv) chk("R6 rsp_out_src", int'(rsp_out_src), m_rsps);
    // next state
    nb = beats_of(int'(req_cmd), int'(req_len));
    for (int i = 0; i < NL; i++) begin
      if (acc && i == sel) m_cnt[i] = 1 + nb;
      else if (rf && i == sel) m_cnt[i] = 1;
      else if (m_cnt[i] > 0) m_cnt[i]--;
    end
    if (req_valid) m_ptr = (m_ptr + 1) % NL;
    fr = rsp_in_valid && m_vld[rsp_in_id];
    m_rspv = fr;
    if (fr) begin
      m_rsps = m_src[rsp_in_id];
      m_vld[rsp_in_id] = 0;
      m_out--;
    end
    if (acc && rec) begin
      m_vld[req_id] = 1;
      m_src[req_id] = int'(req_src);
      m_out++;
    end
    if (acc) begin
      m_pk[int'(req_src) * NL + sel]++;
      m_by[int'(req_src) * NL + sel] += (int'(req_cmd) % 2 == 1) ? int'(req_len) : 0;
      m_cc[int'(req_cmd)]++;
    end
    @(posedge clk);
  endtask

  task automatic set_req(input int id, input bit need, input bit inh, input int cmd,
                         input int len);
    req_addr     = $urandom;
    req_id       = 4'(id);
    req_need_rsp = need;
    req_inhibit  = inh;
    req_cmd      = 2'(cmd);
    req_len      = 8'(len);
    req_src      = 2'($urandom_range(0, 3));
    req_delay    = 8'($urandom);
  endtask

  task automatic idle(input int n);
    bit a;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      req_valid = 0; rsp_in_valid = 0;
      step(a);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit a, pend;
    int r, acc_cnt;
    void'($urandom(32'd20250611));
    m_ptr = 0; m_out = 0; m_rspv = 0; m_rsps = 0;
    for (int i = 0; i < NL; i++) m_cnt[i] = 0;
    for (int i = 0; i < 16; i++) begin m_vld[i] = 0; m_src[i] = 0; m_pk[i] = 0; m_by[i] = 0; end
    for (int i = 0; i < 4; i++) m_cc[i] = 0;
    rst = 1; req_valid = 0; link_ready = 0; rsp_in_valid = 0; rsp_in_id = 0;
    rng_upd_valid = 0; rng_upd_base = 0; rng_upd_last = 0;
    stat_src = 0; stat_dst = 0; stat_cmd = 0;
    set_req(0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    // R11 reset state
    chk("R11 link_busy", int'(link_busy), 0);
    chk("R11 rsp_out_valid", int'(rsp_out_valid), 0);
    chk("R11 range_seen", int'(range_seen), 0);
    chk("R11 range_base", int'(range_base), 0);
    chk("R11 stat_pkts", int'(stat_pkts), 0);
    chk("R11 req_ready", int'(req_ready), 0);
    @(posedge clk);

    // R1 directed walk: no-data requests, all links ready
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      link_ready = 4'hF; req_valid = 1; rsp_in_valid = 0;
      set_req(k, 0, 0, 0, 0);
      step(a);
      chk("R1 walk accept", int'(a), 1);
    end
    idle(2);

    // R3 refusal: all links refuse, each offer costs one busy cycle
    @(negedge clk);
    link_ready = 4'h0; req_valid = 1;
    set_req(3, 0, 0, 1, 40);
    step(a);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      step(a);
      chk("R3 refused", int'(a), 0);
    end
    @(negedge clk);
    link_ready = 4'hF;
    step(a);
    acc_cnt = 0;
    while (!a && acc_cnt < 8) begin
      @(negedge clk); step(a); acc_cnt++;
    end
    chk("R4 accepted after refusals", int'(a), 1);
    idle(20);

    // constrained random phase
    pend = 0;
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      if (!pend && $urandom_range(0, 99) < 70) begin
        set_req($urandom_range(0, 15), $urandom_range(0, 99) < 60,
                $urandom_range(0, 99) < 15, $urandom_range(0, 3), $urandom_range(0, 255));
        pend = 1;
      end
      req_valid = pend;
      link_ready = 4'($urandom) | 4'($urandom);
      r = $urandom_range(0, 15);
      rsp_in_id = 4'(r);
      rsp_in_valid = m_vld[r] && ($urandom_range(0, 3) == 0);
      step(a);
      if (a) pend = 0;
    end
    // finish any held request
    while (pend) begin
      @(negedge clk);
      link_ready = 4'hF;
      r = $urandom_range(0, 15);
      rsp_in_id = 4'(r);
      rsp_in_valid = m_vld[r];
      step(a);
      if (a) pend = 0;
    end
    @(negedge clk); req_valid = 0; rsp_in_valid = 0; step(a);
    // drain the route table
    for (int i = 0; i < 16; i++) begin
      if (m_vld[i]) begin
        @(negedge clk);
        rsp_in_valid = 1; rsp_in_id = 4'(i);
        step(a);
      end
    end
    idle(20);
    chk("R6 table drained", m_out, 0);

    // R8 fill to capacity
    link_ready = 4'hF;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      req_valid = 1; rsp_in_valid = 0;
      set_req(k, 1, 0, 0, 0);
      step(a);
      chk("R8 fill accept", int'(a), 1);
    end
    @(negedge clk);
    set_req(9, 0, 0, 0, 0);
    step(a);
    chk("R8 no-entry request passes while full", int'(a), 1);
    @(negedge clk);
    set_req(5, 1, 0, 0, 0);
    step(a);
    chk("R8 full rejects", int'(a), 0);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); step(a);
      chk("R8 full rejects", int'(a), 0);
    end
    @(negedge clk);
    rsp_in_valid = 1; rsp_in_id = 4'd1;
    step(a);
    chk("R8 still full on free cycle", int'(a), 0);
    @(negedge clk);
    rsp_in_valid = 0;
    step(a);
    chk("R8 accepted after free", int'(a), 1);

    // R7 duplicate ID held until its response frees it
    @(negedge clk);
    set_req(5, 1, 0, 0, 0);
    step(a);
    chk("R7 duplicate rejected", int'(a), 0);
    @(negedge clk); step(a);
    chk("R7 duplicate rejected", int'(a), 0);
    @(negedge clk);
    rsp_in_valid = 1; rsp_in_id = 4'd5;
    step(a);
    @(negedge clk);
    rsp_in_valid = 0;
    step(a);
    chk("R7 accepted after response", int'(a), 1);
    idle(20);

    // R9 range adoption
    @(negedge clk);
    rng_upd_valid = 4'b0100; rng_upd_base = 32'h0000_1000; rng_upd_last = 32'h0000_1FFF;
    @(negedge clk);
    rng_upd_valid = 4'b0000;
    chk("R9 other link ignored", int'(range_base), 0);
    chk("R9 seen mark", int'(range_seen), 4);
    @(negedge clk);
    rng_upd_valid = 4'b0001; rng_upd_base = 32'h0000_2000; rng_upd_last = 32'h0000_2FFF;
    @(negedge clk);
    rng_upd_valid = 4'b0000;
    chk("R9 link 0 base", int'(range_base), 32'h2000);
    chk("R9 link 0 last", int'(range_last), 32'h2FFF);
    chk("R9 seen mark", int'(range_seen), 5);

    // R10 counter readback
    for (int s = 0; s < 4; s++) begin
      for (int d = 0; d < NL; d++) begin
        @(negedge clk);
        stat_src = 2'(s); stat_dst = 2'(d); stat_cmd = 2'(d);
        @(negedge clk);
        chk("R10 pair packets", int'(stat_pkts), m_pk[s * NL + d]);
        chk("R10 pair bytes", int'(stat_bytes), m_by[s * NL + d]);
        chk("R10 command count", int'(stat_cmd_cnt), m_cc[d]);
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule